// File: doc/BRIEF.md
# Serial Channel Command and Status Register Block

This block sits between a processor register bus and a four-channel serial controller port. Software programs a command word with a target channel, the number of bytes expected back and the number of bytes to send, then sets a start bit. The block holds the command until the selected channel is no longer busy, issues a one-cycle start strobe to the transfer engine, and reports the command as pending until the engine signals completion.

A second register collects per-channel status. It holds four sticky error flags (no response, collision, too many bytes, too few bytes), a flag for fresh input data and a flag for an output buffer that has not yet been copied. A summary error bit, a transfer-complete flag and a read-status interrupt appear in the command word. One interrupt line combines the two interrupt sources under their masks. After a commanded transfer, the block flags that channel so that polling can resume on the next vertical blank.

Top module: `serial_cmd_regs`

## Requirements
- R1: After reset, both registers read 0, `irq` is 0, `xferStart` is 0 and `pollResume` is 0.
- R2: The command word is at address 0. Bit 0 is start. Bits 2:1 select the channel, and codes 0..3 address channels 1..4 (index 0..3). Bit 3 is the read-status mask and bit 4 is the transfer-complete mask. Bits 22:16 hold the input length and bits 30:24 the output length. While start reads 1, writes to the channel and length fields have no effect.
- R3: Writing 1 to start while idle queues a command. `xferStart` goes high for exactly one cycle, in the first cycle in which `chanBusy` of the selected channel is 0. `xferChannel` and the lengths are valid in that cycle. Writing 0 to start issues nothing.
- R4: Start (bit 0) reads 1 from the cycle after the start write until `xferDone` is seen for the issued command, and reads 0 after that.
- R5: `xferInLen` and `xferOutLen` carry the byte count. A field value of 0 means 128 and any other value means itself.
- R6: The status word is at address 1, with channel c in bits 8c+7..8c. Bit 0 is no-response, bit 1 collision, bit 2 overrun and bit 3 underrun. These flags are sticky. Writing 1 to a flag bit clears it and writing 0 leaves it alone. A set event in the same cycle as a clear wins.
- R7: `noResponse` and `collision` set their flag on the selected channel. At `xferDone`, if `noResponse` is low, `rxCount` above the decoded input length sets overrun and `rxCount` below it sets underrun.
- R8: Command bit 7 reads 1 exactly when any error flag of any channel is set.
- R9: Status bit 8c+4 is set by `inBufCaptured[c]` and cleared by `inBufRead[c]`. Command bit 5, the read-status interrupt, is 1 while any of these four bits is 1.
- R10: Status bit 8c+5 is set by `outBufWritten[c]` and cleared by `outBufCopied[c]`.
- R11: Command bit 6 is set at `xferDone` and cleared by writing 1 to it. `irq` = (bit 5 AND read mask) OR (bit 6 AND complete mask). The masks never stop bits 5 and 6 from being set.
- R12: A completed command arms its channel. On `vblank` each armed channel is disarmed, and `pollResume[c]` pulses in the following cycle only if `pollEnable[c]` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrite | input | 1 | Register write strobe |
| busAddr | input | 1 | 0 selects the command word, 1 the status word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| xferStart | output | 1 | One-cycle command issue to the transfer engine |
| xferChannel | output | 2 | Channel index of the command |
| xferInLen | output | 8 | Expected reply bytes, 1..128 |
| xferOutLen | output | 8 | Bytes to send, 1..128 |
| chanBusy | input | 4 | Per-channel transaction in progress |
| xferDone | input | 1 | Engine finished the issued command |
| rxCount | input | 8 | Bytes received, valid with xferDone |
| noResponse | input | 1 | No device answered |
| collision | input | 1 | Line collision detected |
| inBufCaptured | input | 4 | New data captured in input buffer |
| inBufRead | input | 4 | Processor read the input buffer |
| outBufWritten | input | 4 | Processor wrote the output buffer |
| outBufCopied | input | 4 | Output buffer copied to the shadow buffer |
| pollEnable | input | 4 | Per-channel poll enable |
| vblank | input | 1 | Vertical blank strobe |
| pollResume | output | 4 | Poll-resume pulse per channel |
| irq | output | 1 | Interrupt to the processor |

## Verification
The command path is driven with directed sequences. One holds the target channel busy so that the start is deferred and the pending write-protection becomes visible. Others return reply counts above, equal to and below the decoded length, with and without a missing response, which separates overrun, underrun and the suppression of both. The buffer-status flags run under seeded random strobes and random write-one-to-clear writes, with simultaneous set and clear included. This shows that bus writes never touch the read-only flags and that the summary interrupt drops only once every channel is drained. Poll resume is tried with the enable both set and clear.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // command word bit positions
  localparam int unsigned CMD_START    = 0;
  localparam int unsigned CMD_CHAN_LSB = 1;
  localparam int unsigned CMD_MASK_RD  = 3;
  localparam int unsigned CMD_MASK_TC  = 4;
  localparam int unsigned CMD_RDST_INT = 5;
  localparam int unsigned CMD_TC_INT   = 6;
  localparam int unsigned CMD_COM_ERR  = 7;
  localparam int unsigned CMD_IN_LSB   = 16;
  localparam int unsigned CMD_OUT_LSB  = 24;
  // status word: one byte per channel
  localparam int unsigned ST_STRIDE = 8;
  localparam int unsigned ST_ERR_N  = 4;
  localparam int unsigned ST_RDST   = 4;
  localparam int unsigned ST_WRST   = 5;

  typedef struct packed {
    logic issue;
    logic done;
  } ctrlStrobes_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [NUM_CH-1:0] chanBusy,
  input  logic              xferDone,
  output logic              pending,
  output logic              xferStart,
  output ctrlStrobes_t      strb
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} state_t;
  state_t state, stateNext;

  always_comb begin
    strb.issue = (state == S_WAIT) && !chanBusy[chanSel];
    strb.done  = (state == S_RUN) && xferDone;
    stateNext  = state;
    case (state)
      S_IDLE:  if (startReq) stateNext = S_WAIT;
      S_WAIT:  if (strb.issue) stateNext = S_RUN;
      S_RUN:   if (xferDone) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  assign pending   = (state != S_IDLE);
  assign xferStart = strb.issue;

  // R3: each queued command issues a single pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    xferStart |=> !xferStart);
  // R4: pending holds until completion is reported
  a_r4_hold_pending: assert property (@(posedge clk) disable iff (rst)
    (pending && !xferDone) |=> pending);
endmodule

// File: rtl/scr_regs.sv
module scr_regs
  import scr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LEN_W  = 7,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrite,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              pending,
  input  ctrlStrobes_t      strb,
  output logic              startReq,
  output logic [CH_W-1:0]   chanSel,
  output logic [CNT_W-1:0]  inLenBytes,
  output logic [CNT_W-1:0]  outLenBytes,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              noResponse,
  input  logic              collision,
  input  logic [NUM_CH-1:0] inBufCaptured,
  input  logic [NUM_CH-1:0] inBufRead,
  input  logic [NUM_CH-1:0] outBufWritten,
  input  logic [NUM_CH-1:0] outBufCopied,
  input  logic [NUM_CH-1:0] pollEnable,
  input  logic              vblank,
  output logic [NUM_CH-1:0] pollResume,
  output logic              irq
);
  localparam int ERR_BITS = NUM_CH * ST_ERR_N;

  logic             cmdWr, stWr;
  logic [LEN_W-1:0] inLenQ, outLenQ;
  logic             maskRd, maskTc, tcInt, rdstInt, comErr;
  logic [ERR_BITS-1:0] errQ, errClr;
  logic [NUM_CH-1:0] rdStQ, wrStQ, armedQ;

  assign cmdWr    = busWrite && !busAddr;
  assign stWr     = busWrite && busAddr;
  assign startReq = cmdWr && busWdata[CMD_START] && !pending;

  // zero encodes the largest count
  assign inLenBytes  = (inLenQ  == '0) ? CNT_W'(1 << LEN_W) : CNT_W'(inLenQ);
  assign outLenBytes = (outLenQ == '0) ? CNT_W'(1 << LEN_W) : CNT_W'(outLenQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      chanSel <= '0;
      inLenQ  <= '0;
      outLenQ <= '0;
      maskRd  <= 1'b0;
      maskTc  <= 1'b0;
      tcInt   <= 1'b0;
    end else begin
      if (cmdWr && !pending) begin
        chanSel <= busWdata[CMD_CHAN_LSB +: CH_W];
        inLenQ  <= busWdata[CMD_IN_LSB +: LEN_W];
        outLenQ <= busWdata[CMD_OUT_LSB +: LEN_W];
      end
      if (cmdWr) begin
        maskRd <= busWdata[CMD_MASK_RD];
        maskTc <= busWdata[CMD_MASK_TC];
      end
      tcInt <= (tcInt & ~(cmdWr & busWdata[CMD_TC_INT])) | strb.done;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic isSel;
    logic [ST_ERR_N-1:0] errSet;
    assign isSel = (chanSel == CH_W'(c));
    assign errSet[0] = isSel && noResponse;
    assign errSet[1] = isSel && collision;
    assign errSet[2] = isSel && strb.done && !noResponse && (rxCount > inLenBytes);
    assign errSet[3] = isSel && strb.done && !noResponse && (rxCount < inLenBytes);
    assign errClr[c*ST_ERR_N +: ST_ERR_N] =
      {ST_ERR_N{stWr}} & busWdata[c*ST_STRIDE +: ST_ERR_N];

    always_ff @(posedge clk) begin
      if (rst) begin
        errQ[c*ST_ERR_N +: ST_ERR_N] <= '0;
        rdStQ[c]  <= 1'b0;
        wrStQ[c]  <= 1'b0;
        armedQ[c] <= 1'b0;
        pollResume[c] <= 1'b0;
      end else begin
        errQ[c*ST_ERR_N +: ST_ERR_N] <=
          (errQ[c*ST_ERR_N +: ST_ERR_N] & ~errClr[c*ST_ERR_N +: ST_ERR_N]) | errSet;
        rdStQ[c]  <= (rdStQ[c] & ~inBufRead[c]) | inBufCaptured[c];
        wrStQ[c]  <= (wrStQ[c] & ~outBufCopied[c]) | outBufWritten[c];
        armedQ[c] <= (armedQ[c] & ~vblank) | (isSel && strb.done);
        pollResume[c] <= vblank && armedQ[c] && pollEnable[c];
      end
    end
  end

  assign rdstInt = |rdStQ;
  assign comErr  = |errQ;
  assign irq     = (rdstInt && maskRd) || (tcInt && maskTc);

  always_comb begin
    busRdata = '0;
    if (!busAddr) begin
      busRdata[CMD_START]                 = pending;
      busRdata[CMD_CHAN_LSB +: CH_W]      = chanSel;
      busRdata[CMD_MASK_RD]               = maskRd;
      busRdata[CMD_MASK_TC]               = maskTc;
      busRdata[CMD_RDST_INT]              = rdstInt;
      busRdata[CMD_TC_INT]                = tcInt;
      busRdata[CMD_COM_ERR]               = comErr;
      busRdata[CMD_IN_LSB +: LEN_W]       = inLenQ;
      busRdata[CMD_OUT_LSB +: LEN_W]      = outLenQ;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        busRdata[c*ST_STRIDE +: ST_ERR_N] = errQ[c*ST_ERR_N +: ST_ERR_N];
        busRdata[c*ST_STRIDE + ST_RDST]   = rdStQ[c];
        busRdata[c*ST_STRIDE + ST_WRST]   = wrStQ[c];
      end
    end
  end

  // R2: command fields frozen while a command is outstanding
  a_r2_cfg_stable: assert property (@(posedge clk) disable iff (rst)
    pending |=> ($stable(chanSel) && $stable(inLenQ) && $stable(outLenQ)));
  // R6: a set flag survives unless its clear bit was written
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(errQ) & ~$past(errClr)) & ~errQ) == '0));
  // R12: resume only on channels whose poll enable was set
  a_r12_resume_enabled: assert property (@(posedge clk) disable iff (rst)
    ((pollResume & ~$past(pollEnable)) == '0));
  // R11: with both masks clear the line stays low
  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!maskRd && !maskTc) |-> !irq);
endmodule

// File: rtl/serial_cmd_regs.sv
module serial_cmd_regs
  import scr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int LEN_W  = 7,
  parameter int DATA_W = 32,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrite,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              xferStart,
  output logic [CH_W-1:0]   xferChannel,
  output logic [CNT_W-1:0]  xferInLen,
  output logic [CNT_W-1:0]  xferOutLen,
  input  logic [NUM_CH-1:0] chanBusy,
  input  logic              xferDone,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              noResponse,
  input  logic              collision,
  input  logic [NUM_CH-1:0] inBufCaptured,
  input  logic [NUM_CH-1:0] inBufRead,
  input  logic [NUM_CH-1:0] outBufWritten,
  input  logic [NUM_CH-1:0] outBufCopied,
  input  logic [NUM_CH-1:0] pollEnable,
  input  logic              vblank,
  output logic [NUM_CH-1:0] pollResume,
  output logic              irq
);
  ctrlStrobes_t strb;
  logic pending, startReq;

  scr_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .chanSel(xferChannel),
    .chanBusy(chanBusy), .xferDone(xferDone), .pending(pending),
    .xferStart(xferStart), .strb(strb)
  );

  scr_regs #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pending(pending), .strb(strb),
    .startReq(startReq), .chanSel(xferChannel), .inLenBytes(xferInLen),
    .outLenBytes(xferOutLen), .rxCount(rxCount), .noResponse(noResponse),
    .collision(collision), .inBufCaptured(inBufCaptured), .inBufRead(inBufRead),
    .outBufWritten(outBufWritten), .outBufCopied(outBufCopied),
    .pollEnable(pollEnable), .vblank(vblank), .pollResume(pollResume), .irq(irq)
  );
endmodule

// File: tb/serial_cmd_regs_test.sv
module serial_cmd_regs_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic busWrite = 1'b0, busAddr = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic xferStart;
  logic [1:0] xferChannel;
  logic [7:0] xferInLen, xferOutLen, rxCount = '0;
  logic [3:0] chanBusy = '0, inBufCaptured = '0, inBufRead = '0;
  logic [3:0] outBufWritten = '0, outBufCopied = '0, pollEnable = '0, pollResume;
  logic xferDone = 1'b0, noResponse = 1'b0, collision = 1'b0, vblank = 1'b0, irq;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cmd_regs uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmdWord(bit st, logic [1:0] ch, bit mr, bit mt,
      bit ri, bit ti, bit ce, logic [6:0] il, logic [6:0] ol);
    return {1'b0, ol, 1'b0, il, 8'b0, ce, ti, ri, mt, mr, ch, st};
  endfunction

  function automatic logic [7:0] lenDecode(logic [6:0] f);
    return (f == 0) ? 8'd128 : {1'b0, f};
  endfunction

  task automatic wr(bit a, logic [31:0] d);
    @(negedge clk); busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rd(bit a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic finishDone(logic [7:0] rx, bit nr);
    @(negedge clk); xferDone = 1'b1; rxCount = rx; noResponse = nr;
    @(negedge clk); xferDone = 1'b0; noResponse = 1'b0;
  endtask

  // queue a command on an idle channel, let it issue, then complete it
  task automatic runCmd(logic [1:0] ch, logic [6:0] il, logic [7:0] rx, bit nr);
    wr(0, cmdWord(1, ch, 0, 0, 0, 0, 0, il, 7'd1));
    finishDone(rx, nr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    logic [3:0] mRd, mWr;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(0, d); chk("R1 command", d, 0);
    rd(1, d); chk("R1 status", d, 0);
    chk("R1 irq/start/resume", {irq, xferStart, pollResume}, 0);

    // R3 start deferred by busy channel 3 (code 2)
    chanBusy = 4'b0100;
    wr(0, cmdWord(1, 2'd2, 0, 0, 0, 0, 0, 7'd0, 7'd5));
    rd(0, d); chk("R4 start reads pending", d[0], 1);
    repeat (3) begin @(negedge clk); chk("R3 held while busy", xferStart, 0); end
    // R2 field write ignored while pending
    wr(0, cmdWord(0, 2'd0, 0, 0, 0, 0, 0, 7'd3, 7'd9));
    rd(0, d); chk("R2 fields frozen", d, cmdWord(1, 2'd2, 0, 0, 0, 0, 0, 7'd0, 7'd5));
    chanBusy = 4'b0000; #1;
    chk("R3 issue pulse", xferStart, 1);
    chk("R3 channel", xferChannel, 2);
    chk("R5 zero means 128", xferInLen, 128);
    chk("R5 out length", xferOutLen, 5);
    @(negedge clk); chk("R3 single pulse", xferStart, 0);
    rd(0, d); chk("R4 running still pending", d[0], 1);
    finishDone(8'd128, 0);
    rd(0, d); chk("R4 R11 done clears start, sets complete",
                  d, cmdWord(0, 2'd2, 0, 0, 0, 1, 0, 7'd0, 7'd5));
    rd(1, d); chk("R7 exact count no error", d, 0);
    chk("R11 masked irq low", irq, 0);

    // R3 writing 0 to start issues nothing
    wr(0, cmdWord(0, 2'd1, 0, 1, 0, 0, 0, 7'd4, 7'd4));
    @(negedge clk); chk("R3 no start on zero", xferStart, 0);
    rd(0, d); chk("R3 R11 idle, tc mask gives irq", {d[0], irq}, 2'b01);
    wr(0, cmdWord(0, 2'd1, 0, 0, 0, 1, 0, 7'd4, 7'd4));
    rd(0, d); chk("R11 complete flag cleared", {d[6], irq}, 0);

    // R7 overrun on channel index 0
    runCmd(2'd0, 7'd4, 8'd6, 0);
    rd(1, d); chk("R7 overrun", d, 32'h4);
    rd(0, d); chk("R8 summary set", d[7], 1);
    wr(1, 32'h0);
    rd(1, d); chk("R6 write 0 keeps flag", d, 32'h4);
    wr(1, 32'h4);
    rd(1, d); chk("R6 write 1 clears", d, 0);
    rd(0, d); chk("R8 summary clear", d[7], 0);

    // R7 underrun, then no-response suppressing compare
    runCmd(2'd1, 7'd4, 8'd2, 0);
    rd(1, d); chk("R7 underrun", d, 32'h0800);
    runCmd(2'd1, 7'd4, 8'd0, 1);
    rd(1, d); chk("R7 no response only", d, 32'h0900);
    // R6 set wins against a same-cycle clear
    @(negedge clk); collision = 1'b1; busWrite = 1'b1; busAddr = 1'b1; busWdata = 32'h0200;
    @(negedge clk); collision = 1'b0; busWrite = 1'b0; busWdata = '0;
    rd(1, d); chk("R6 set beats clear", d, 32'h0B00);
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R6 clear all", d, 0);

    // R12 poll resume: channel 1 armed and enabled, channel 0 armed but disabled
    runCmd(2'd0, 7'd1, 8'd1, 0);
    runCmd(2'd1, 7'd1, 8'd1, 0);
    pollEnable = 4'b0010;
    @(negedge clk); chk("R12 no resume before vblank", pollResume, 0);
    vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
    chk("R12 resume enabled only", pollResume, 4'b0010);
    vblank = 1'b1;
    @(negedge clk); vblank = 1'b0;
    chk("R12 disarmed after vblank", pollResume, 0);
    pollEnable = 4'b0000;

    // R9 R10 R11 random buffer strobes with read mask enabled
    wr(0, cmdWord(0, 2'd1, 1, 0, 0, 1, 0, 7'd1, 7'd1));
    mRd = '0; mWr = '0;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] cap, rdS, wrS, cpS;
      logic [31:0] wd;
      cap = 4'($urandom) & 4'($urandom);
      rdS = 4'($urandom);
      wrS = 4'($urandom) & 4'($urandom);
      cpS = 4'($urandom);
      wd  = $urandom;
      @(negedge clk);
      inBufCaptured = cap; inBufRead = rdS; outBufWritten = wrS; outBufCopied = cpS;
      busWrite = ($urandom % 4 == 0); busAddr = 1'b1; busWdata = wd & 32'h3030_3030;
      @(negedge clk);
      inBufCaptured = '0; inBufRead = '0; outBufWritten = '0; outBufCopied = '0;
      busWrite = 1'b0; busWdata = '0;
      mRd = (mRd & ~rdS) | cap;
      mWr = (mWr & ~cpS) | wrS;
      rd(1, d);
      chk("R9 R10 buffer flags", d,
          {2'b0, mWr[3], mRd[3], 4'b0, 2'b0, mWr[2], mRd[2], 4'b0,
           2'b0, mWr[1], mRd[1], 4'b0, 2'b0, mWr[0], mRd[0], 4'b0});
      rd(0, d);
      chk("R9 R11 read interrupt and irq", {d[5], irq}, {|mRd, |mRd});
    end
    // R9 interrupt drops only once every channel is read
    @(negedge clk); inBufCaptured = 4'b1001;
    @(negedge clk); inBufCaptured = '0; inBufRead = 4'b0001;
    @(negedge clk); inBufRead = '0;
    rd(0, d); chk("R9 one channel left", d[5], 1);
    inBufRead = 4'b1111;
    @(negedge clk); inBufRead = '0;
    rd(0, d); chk("R9 all read", {d[5], irq}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule